// File: doc/BRIEF.md
# SPI-NAND Phase Transfer Engine

A memory-mapped host engine for SPI-NAND flash that moves one phase of a flash command per register trigger. Software builds each flash operation out of phases (opcode, address, dummy, data). For every phase it writes a command word giving a byte count of 1 to 4 and a lane width of 1, 2 or 4 lines. An outgoing phase starts when the data word is written next. An incoming phase starts on the command write itself, and its bytes are left-aligned in a read data register.

Chip select is a plain register. It is not tied to the phases, so a device stays selected across all the phases of one operation until software deselects it. A status register shows whether a phase is running and in which direction. The serial clock is the system clock divided by two and idles low. Outputs change while the clock is low, and inputs are sampled on its rising edge.

Top module: `spinand_xfer_engine`

## Requirements
- R1: After reset both chip selects are high, `sck` is low, `io_oe` is zero, and status (0x40) and read data (0x10) read as zero.
- R2: A write to 0x04 stores the word, which reads back unchanged. Chip select n is driven low exactly when bit 4*n of the stored word is 0, so all ones deselects both devices.
- R3: A write to 0x08 arms an outgoing phase. Bits 1:0 give the byte count minus one. Bits 29:28 select the lanes: 0 for one lane, 1 for two, 2 for four, and 3 for one lane. The next write to 0x14 shifts out that many bytes, starting from bits 31:24, most significant bit first.
- R4: A write to 0x14 with no armed command causes no serial activity. One arming allows exactly one outgoing phase.
- R5: An outgoing phase on one lane drives only `io_out[0]` (`io_oe`=0001). On two lanes it drives `io_out[1:0]`, and on four lanes `io_out[3:0]`, with the higher-numbered line carrying the more significant bit.
- R6: A write to 0x0C with the same field layout starts an incoming phase. One lane samples `io_in[1]`, two lanes `io_in[1:0]`, and four lanes `io_in[3:0]`. The first byte lands in bits 31:24 of 0x10, the unused lower bytes read zero, and the value holds until the next incoming phase.
- R7: `sck` is the clock divided by two and is low whenever no phase runs. A phase of N = 8*bytes/lanes steps runs busy for exactly 2*N cycles.
- R8: Status bit 3 reads 1 while a phase runs. Bit 2 is 1 during an incoming phase and bit 1 during an outgoing one. All other bits read 0.
- R9: Writes to 0x08, 0x0C or 0x14 while a phase runs are ignored.
- R10: Chip select is not changed by phases and stays asserted across consecutive phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from address) |
| cs_n | output | NUM_CS | Active-low chip selects |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | Serial data out lines |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Serial data in lines |

## Verification
A write that starts a phase is registered on one edge. Busy and the status direction bits are visible in the following cycle. Busy then clears exactly 2*N cycles after that edge, and read data is final from that same cycle. The bench drives the bus at falling edges and samples at falling edges. It counts cycles from the starting write until status clears and compares that count against 2*N. A serial monitor records outgoing bits at each rising `sck` and checks every finished frame against the scoreboard entry queued by the driver. Chip-select changes are checked one cycle after the register write.

// File: rtl/spinand_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the SPI-NAND phase engine.
// Assumes a 32-bit register bus with byte addresses and stride 4.
package spinand_pkg;
    localparam int WORD_W  = 32;
    localparam int IO_W    = 4;
    localparam int STEP_W  = 6;

    localparam logic [7:0] OFS_CSEL   = 8'h04;
    localparam logic [7:0] OFS_WCMD   = 8'h08;
    localparam logic [7:0] OFS_RCMD   = 8'h0C;
    localparam logic [7:0] OFS_RDATA  = 8'h10;
    localparam logic [7:0] OFS_WDATA  = 8'h14;
    localparam logic [7:0] OFS_STATUS = 8'h40;

    localparam int ST_BUSY = 3;
    localparam int ST_RD   = 2;
    localparam int ST_WR   = 1;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd2
    } lane_t;

    // Map the raw width code; the spare code falls back to one lane.
    function automatic lane_t lane_decode(input logic [1:0] code);
        case (code)
            2'd1:    return LANE_X2;
            2'd2:    return LANE_X4;
            default: return LANE_X1;
        endcase
    endfunction
endpackage

// File: rtl/spinand_shifter.sv
`timescale 1ns/1ps
// Serializer/deserializer for one phase of 1..4 bytes on 1, 2 or 4 lines.
// Generates sck = clk/2, idle low; drives while sck low, samples on rise.
// Assumes start is only pulsed while busy is low.
module spinand_shifter
    import spinand_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [1:0]        start_len,
    input  logic [1:0]        start_wid,
    input  logic [WORD_W-1:0] start_word,
    output logic              busy,
    output logic              is_rd,
    output logic              sck,
    output logic [IO_W-1:0]   io_out,
    output logic [IO_W-1:0]   io_oe,
    input  logic [IO_W-1:0]   io_in,
    output logic [WORD_W-1:0] rx_word
);
    logic              busy_q, rd_q, sck_q;
    lane_t             lw_q;
    logic [1:0]        len_q;
    logic [STEP_W-1:0] steps_q;
    logic [WORD_W-1:0] tx_sr, rx_sr;
    logic [WORD_W-1:0] tx_next, rx_next;
    logic [STEP_W-1:0] steps_init;
    lane_t             lw_start;

    // Step count for a new phase: bits divided by lane count.
    always_comb begin
        lw_start   = lane_decode(start_wid);
        steps_init = {({1'b0, start_len} + 3'd1), 3'b000} >> lw_start;
    end

    // Next shift register contents for the current lane width.
    always_comb begin
        case (lw_q)
            LANE_X2: begin
                tx_next = {tx_sr[WORD_W-3:0], 2'b00};
                rx_next = {rx_sr[WORD_W-3:0], io_in[1:0]};
            end
            LANE_X4: begin
                tx_next = {tx_sr[WORD_W-5:0], 4'b0000};
                rx_next = {rx_sr[WORD_W-5:0], io_in[3:0]};
            end
            default: begin
                tx_next = {tx_sr[WORD_W-2:0], 1'b0};
                rx_next = {rx_sr[WORD_W-2:0], io_in[1]};
            end
        endcase
    end

    // Phase sequencer: load, then alternate sck rise (sample) and fall (shift).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            rd_q    <= 1'b0;
            sck_q   <= 1'b0;
            lw_q    <= LANE_X1;
            len_q   <= 2'd3;
            steps_q <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                rd_q    <= start_rd;
                lw_q    <= lw_start;
                steps_q <= steps_init;
                tx_sr   <= start_word;
                sck_q   <= 1'b0;
                if (start_rd) begin
                    rx_sr <= '0;
                    len_q <= start_len;
                end
            end
        end else if (!sck_q) begin
            sck_q <= 1'b1;
            if (rd_q) rx_sr <= rx_next;
        end else begin
            sck_q <= 1'b0;
            tx_sr <= tx_next;
            if (steps_q == STEP_W'(1)) busy_q <= 1'b0;
            else                       steps_q <= steps_q - 1'b1;
        end
    end

    // Output line drive for outgoing phases only.
    always_comb begin
        io_out = '0;
        io_oe  = '0;
        if (busy_q && !rd_q) begin
            case (lw_q)
                LANE_X2: begin io_out = {2'b00, tx_sr[WORD_W-1 -: 2]}; io_oe = 4'b0011; end
                LANE_X4: begin io_out = tx_sr[WORD_W-1 -: 4];          io_oe = 4'b1111; end
                default: begin io_out = {3'b000, tx_sr[WORD_W-1]};     io_oe = 4'b0001; end
            endcase
        end
    end

    // Left-align received bits; unused low bytes become zero.
    assign rx_word = rx_sr << {~len_q, 3'b000};
    assign busy    = busy_q;
    assign is_rd   = rd_q;
    assign sck     = sck_q;
endmodule

// File: rtl/spinand_regs.sv
`timescale 1ns/1ps
// Register decode: chip-select word, armed write command, read command
// trigger, read data and status. Assumes single-cycle write strobes.
module spinand_regs
    import spinand_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              is_rd,
    input  logic [WORD_W-1:0] rx_word,
    output logic              start,
    output logic              start_rd,
    output logic [1:0]        start_len,
    output logic [1:0]        start_wid,
    output logic [WORD_W-1:0] start_word,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int CS_STRIDE = 4;

    logic [WORD_W-1:0] csel_q, wcmd_q;
    logic              armed_q;
    logic              hit_csel, hit_wcmd, hit_rcmd, hit_wdata;

    // Address decode of write strobes.
    always_comb begin
        hit_csel  = bus_we && (bus_addr == ADDR_W'(OFS_CSEL));
        hit_wcmd  = bus_we && (bus_addr == ADDR_W'(OFS_WCMD));
        hit_rcmd  = bus_we && (bus_addr == ADDR_W'(OFS_RCMD));
        hit_wdata = bus_we && (bus_addr == ADDR_W'(OFS_WDATA));
    end

    // Phase launch: reads start on command, writes on data when armed.
    always_comb begin
        start_rd   = hit_rcmd && !busy;
        start      = start_rd || (hit_wdata && armed_q && !busy);
        start_len  = start_rd ? bus_wdata[1:0]   : wcmd_q[1:0];
        start_wid  = start_rd ? bus_wdata[29:28] : wcmd_q[29:28];
        start_word = bus_wdata;
    end

    // Register state: chip select, write command and arming flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csel_q  <= '1;
            wcmd_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            if (hit_csel) csel_q <= bus_wdata;
            if (hit_wcmd && !busy) begin
                wcmd_q  <= bus_wdata;
                armed_q <= 1'b1;
            end else if (start && !start_rd) begin
                armed_q <= 1'b0;
            end
        end
    end

    // One select line per device, taken every CS_STRIDE bits.
    for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
        assign cs_n[n] = csel_q[n*CS_STRIDE];
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CSEL):  bus_rdata = csel_q;
            ADDR_W'(OFS_WCMD):  bus_rdata = wcmd_q;
            ADDR_W'(OFS_RDATA): bus_rdata = rx_word;
            ADDR_W'(OFS_STATUS): begin
                bus_rdata[ST_BUSY] = busy;
                bus_rdata[ST_RD]   = busy && is_rd;
                bus_rdata[ST_WR]   = busy && !is_rd;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spinand_xfer_engine.sv
`timescale 1ns/1ps
// Top of the SPI-NAND phase engine: register block plus serial shifter.
// Software sequences opcode/address/dummy/data as separate phases.
module spinand_xfer_engine
    import spinand_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CS-1:0] cs_n,
    output logic              sck,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);
    logic              busy, xfer_rd, start, start_rd;
    logic [1:0]        start_len, start_wid;
    logic [WORD_W-1:0] start_word, rx_word;

    spinand_regs #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy(busy), .is_rd(xfer_rd), .rx_word(rx_word),
        .start(start), .start_rd(start_rd), .start_len(start_len),
        .start_wid(start_wid), .start_word(start_word), .cs_n(cs_n)
    );

    spinand_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_rd(start_rd), .start_len(start_len),
        .start_wid(start_wid), .start_word(start_word),
        .busy(busy), .is_rd(xfer_rd), .sck(sck),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rx_word(rx_word)
    );
endmodule

// File: rtl/spinand_xfer_engine_chk.sv
`timescale 1ns/1ps
// Property checker for the phase engine, bound to the top module.
module spinand_xfer_engine_chk #(
    parameter int ADDR_W = 8,
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sck,
    input logic [3:0]        io_oe,
    input logic              busy
);
    // R7: serial clock stays low when no phase runs.
    a_r7_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R7: serial clock toggles every cycle while a phase continues.
    a_r7_sck_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (sck != $past(sck)));

    // R5: only the legal lane enable patterns, and only during a phase.
    a_r5_oe_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0000) || (busy && (io_oe == 4'b0001 || io_oe == 4'b0011
                                        || io_oe == 4'b1111)));

    // R9: a phase only begins right after a trigger register write.
    a_r9_start_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(bus_we) && ($past(bus_addr) == ADDR_W'(8'h14)
                                        || $past(bus_addr) == ADDR_W'(8'h0C))));

    // R2: each select follows its bit of the written chip-select word.
    for (genvar n = 0; n < NUM_CS; n++) begin : g_cs_chk
        a_r2_cs_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(8'h04)) |=> (cs_n[n] == $past(bus_wdata[4*n])));
    end
endmodule

bind spinand_xfer_engine spinand_xfer_engine_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cs_n(cs_n), .sck(sck), .io_oe(io_oe), .busy(busy)
);

// File: tb/spinand_xfer_engine_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver queues expected frames, monitor checks them.
module spinand_xfer_engine_test;
    typedef struct {
        logic [31:0] val;
        int          bits;
        logic [3:0]  oe;
    } frame_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cs_n;
    logic        sck;
    logic [3:0]  io_out, io_oe, io_in;

    int nchk = 0, nerr = 0, nframes = 0;
    frame_t exp_q[$];
    logic [31:0] cap = '0;
    int          capn = 0;
    logic [3:0]  last_oe = '0;
    logic        prev_sck = 1'b0;
    logic [3:0]  prev_oe = '0;
    logic [31:0] dev_word = '0;
    int          dev_lanes = 1;

    always #10 clk = ~clk;

    spinand_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cs_n(cs_n),
        .sck(sck), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    // Flash model output: top bits of dev_word on the lines of the lane mode.
    always_comb begin
        case (dev_lanes)
            2:       io_in = {2'b00, dev_word[31:30]};
            4:       io_in = dev_word[31:28];
            default: io_in = {2'b00, dev_word[31], 1'b0};
        endcase
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: capture on sck rise, close frame when output enables drop.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck && !prev_sck && (|io_oe)) begin
                last_oe = io_oe;
                case (io_oe)
                    4'b0011: begin cap = {cap[29:0], io_out[1:0]}; capn += 2; end
                    4'b1111: begin cap = {cap[27:0], io_out[3:0]}; capn += 4; end
                    default: begin cap = {cap[30:0], io_out[0]};   capn += 1; end
                endcase
            end
            if (prev_sck && !sck) dev_word = dev_word << dev_lanes;
            if (prev_oe != 4'b0000 && io_oe == 4'b0000) begin
                nframes++;
                if (exp_q.size() == 0) begin
                    check("R4 unexpected frame", 32'(capn), 32'd0);
                end else begin
                    frame_t f;
                    f = exp_q.pop_front();
                    check("R3 frame bits", 32'(capn), 32'(f.bits));
                    check("R3 frame value", cap << (32 - capn), f.val);
                    check("R5 lane enables", {28'd0, last_oe}, {28'd0, f.oe});
                end
                cap = '0;
                capn = 0;
            end
        end
        prev_sck = sck;
        prev_oe  = io_oe;
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Count cycles from the starting write until status reports idle.
    task automatic wait_idle(output int cnt);
        logic [31:0] st;
        cnt = 0;
        bus_read(8'h40, st);
        while (st[3] && cnt < 1000) begin
            @(negedge clk);
            cnt++;
            bus_read(8'h40, st);
        end
    endtask

    function automatic logic [31:0] cmd(input int bytes, input logic [1:0] wid);
        return {2'b00, wid, 26'd0, 2'(bytes - 1)};
    endfunction

    function automatic int lanes_of(input logic [1:0] wid);
        return (wid == 2'd1) ? 2 : (wid == 2'd2) ? 4 : 1;
    endfunction

    task automatic do_write(input int bytes, input logic [1:0] wid, input logic [31:0] w);
        frame_t f;
        int cnt, ln;
        logic [31:0] st;
        ln = lanes_of(wid);
        f.val  = w & (32'hFFFF_FFFF << (32 - 8*bytes));
        f.bits = 8*bytes;
        f.oe   = (ln == 4) ? 4'b1111 : (ln == 2) ? 4'b0011 : 4'b0001;
        bus_write(8'h08, cmd(bytes, wid));
        exp_q.push_back(f);
        bus_write(8'h14, w);
        bus_read(8'h40, st);
        check("R8 status outgoing", st, 32'h0000_000A);
        wait_idle(cnt);
        check("R7 outgoing duration", 32'(cnt), 32'(2*8*bytes/ln));
        check("R7 sck idle low", {31'd0, sck}, 32'd0);
    endtask

    task automatic do_read(input int bytes, input logic [1:0] wid, input logic [31:0] dv);
        int cnt, ln;
        logic [31:0] st, rd;
        ln = lanes_of(wid);
        dev_word  = dv;
        dev_lanes = ln;
        bus_write(8'h0C, cmd(bytes, wid));
        bus_read(8'h40, st);
        check("R8 status incoming", st, 32'h0000_000C);
        wait_idle(cnt);
        check("R7 incoming duration", 32'(cnt), 32'(2*8*bytes/ln));
        bus_read(8'h10, rd);
        check("R6 read data", rd, dv & (32'hFFFF_FFFF << (32 - 8*bytes)));
    endtask

    initial begin
        #(20 * 200000);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cnt, nf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cs_n", {30'd0, cs_n}, 32'd3);
        check("R1 sck", {31'd0, sck}, 32'd0);
        check("R1 io_oe", {28'd0, io_oe}, 32'd0);
        bus_read(8'h40, v); check("R1 status", v, 32'd0);
        bus_read(8'h10, v); check("R1 read data", v, 32'd0);

        // R2 chip select control
        bus_write(8'h04, 32'hFFFF_FFFE);
        check("R2 select cs0", {30'd0, cs_n}, 32'd2);
        bus_read(8'h04, v); check("R2 readback", v, 32'hFFFF_FFFE);
        bus_write(8'h04, 32'hFFFF_FFEF);
        check("R2 select cs1", {30'd0, cs_n}, 32'd1);
        bus_write(8'h04, 32'hFFFF_FFFF);
        check("R2 deselect all", {30'd0, cs_n}, 32'd3);

        // R3 R5 R10 outgoing phases with cs0 held low across them
        bus_write(8'h04, 32'hFFFF_FFFE);
        do_write(1, 2'd0, 32'h9F00_0000);
        check("R10 cs held", {30'd0, cs_n}, 32'd2);
        do_write(3, 2'd0, 32'h1300_1234);
        do_write(4, 2'd1, 32'hA5C3_5A3C);
        do_write(2, 2'd2, 32'hDEAD_7777);
        do_write(1, 2'd3, 32'h6B00_0000);
        check("R10 cs held after phases", {30'd0, cs_n}, 32'd2);

        // R6 incoming phases
        do_read(4, 2'd0, 32'h1234_5678);
        do_read(2, 2'd2, 32'hBEEF_0000);
        do_read(3, 2'd1, 32'hCAFE_7700);
        do_read(1, 2'd0, 32'h5A00_0000);
        do_write(2, 2'd0, 32'h0F0F_0000);
        bus_read(8'h10, v); check("R6 read data holds", v, 32'h5A00_0000);

        // R4 data write without arming, and reuse after a phase
        nf = nframes;
        bus_write(8'h14, 32'hFFFF_FFFF);
        repeat (80) @(negedge clk);
        bus_read(8'h40, v); check("R4 no phase status", v, 32'd0);
        check("R4 no frame", 32'(nframes), 32'(nf));

        // R9 trigger writes while busy are ignored
        bus_write(8'h08, cmd(4, 2'd0));
        bus_write(8'h14, 32'h3C3C_3C3C);
        exp_q.push_back('{val: 32'h3C3C_3C3C, bits: 32, oe: 4'b0001});
        bus_write(8'h0C, cmd(1, 2'd0));
        bus_write(8'h08, cmd(1, 2'd0));
        bus_write(8'h14, 32'h0100_0000);
        wait_idle(cnt);
        check("R9 duration unchanged", 32'(cnt), 32'd58);
        bus_read(8'h10, v); check("R9 read data unchanged", v, 32'h5A00_0000);
        nf = nframes;
        bus_write(8'h14, 32'hAAAA_AAAA);
        repeat (80) @(negedge clk);
        check("R9 command ignored so no frame", 32'(nframes), 32'(nf));
        bus_read(8'h08, v); check("R9 command register kept", v, cmd(4, 2'd0));

        bus_write(8'h04, 32'hFFFF_FFFF);
        check("R10 deselect after op", {30'd0, cs_n}, 32'd3);
        check("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule